// File: doc/BRIEF.md
# IR receive byte buffer with interrupt status

This block sits behind an infrared sampler. The sampler turns each run of the received signal into a byte: a polarity bit and a run length. The block stores those bytes in a small first-in first-out buffer until software drains them. It also keeps the receive status and forms one interrupt line from it. The sampler pushes bytes with a one-cycle valid strobe, and it pulses a separate strobe when it sees the idle gap that ends a packet.

Software reaches the block through a small register port. The port has a 2-bit select, a write strobe, a read strobe and a combinational read bus. Three registers are used: the buffer data, the interrupt enables together with a trigger level, and the status word. The status word carries two sticky event flags (overflow and packet end), which are cleared by writing ones. It also carries a live data-available flag, which compares the stored byte count with the trigger level, and the byte count itself. The interrupt line is high while any status flag is set together with its enable.

The buffer depth is a parameter (64 bytes by default). Any depth of two or more is accepted. When the depth is not a power of two, the pointers wrap by compare.

Top module: `ir_rx_buffer`

## Requirements
- R1: After reset the status word, the enable register and the data read all read as 0, and `irq` is low.
- R2: Select 0 is the data register. While `reg_rd` is high with select 0, `reg_rdata[7:0]` shows the oldest stored byte and that byte is removed at the clock edge. Bytes come out in the order they were pushed.
- R3: Select 2 is the status word. Its bits [8 +: CW], with CW = clog2(2*DEPTH), hold the number of stored bytes (0 to DEPTH).
- R4: A pushed byte that arrives while the buffer is full and no byte leaves in the same cycle is dropped. It sets the sticky overflow flag at status bit 0, and the stored contents stay unchanged.
- R5: A data read from an empty buffer returns 0 and leaves the count and the flags unchanged.
- R6: A pulse on `smp_pkt_end` sets the sticky packet-end flag at status bit 1.
- R7: Writing the status word clears bit 0 and bit 1 where the written value has a one, and leaves them where it has a zero. An event that arrives in the same cycle as its clear wins, so the flag stays set.
- R8: Status bit 4 (data available) is high exactly while the byte count is greater than the trigger level. It is not affected by status writes.
- R9: `irq` is high exactly while (bit 0 and enable bit 0) or (bit 1 and enable bit 1) or (bit 4 and enable bit 4) holds.
- R10: When the buffer is full and a push and a data read happen in the same cycle, both take effect, the count stays at DEPTH and no overflow is flagged.
- R11: Select 1 is the enable register. Bits 0, 1 and 4 are the enables and bits [8 +: clog2(DEPTH)] are the trigger level. It reads back what was written in those fields, and every other bit reads 0. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Run-length byte from the sampler |
| smp_pkt_end | input | 1 | Packet-end pulse from the sampler |
| reg_sel | input | 2 | Register select: 0 data, 1 enables, 2 status, 3 unused |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the buffer on select 0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on the select |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. The count never exceeds the depth and never moves on an empty read. The overflow flag stays until a one is written to clear it, and a packet-end pulse is always recorded. A live enabled available flag always raises the interrupt, and the interrupt is low when no flag is set. Only the bench's scenarios can show the rest. These are the byte order through a full buffer and its wrap, which byte is dropped on overflow, the simultaneous push and pop at the full boundary, the exact trigger-level edge, and the race between a set event and its clear, all checked against a queue model every clock.

// File: rtl/ir_rxbuf_pkg.sv
package ir_rxbuf_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_IEN  = 2'd1,
      SEL_STAT = 2'd2,
      SEL_RSVD = 2'd3
   } rxbuf_sel_e;

   localparam int BIT_OVF   = 0;
   localparam int BIT_PEND  = 1;
   localparam int BIT_AVAIL = 4;
   localparam int FIELD_LSB = 8;

   typedef struct packed {
      logic avail;
      logic pend;
      logic ovf;
   } rxbuf_flags_t;

endpackage

// File: rtl/ir_rxbuf_store.sv
module ir_rxbuf_store #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(2 * DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ir_rxbuf_store: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ir_rxbuf_store: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW-1:0]     wr_nxt, rd_nxt;

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_nxt;
         end
         if (pop) begin
            rd_ptr <= rd_nxt;
         end
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = empty ? '0 : mem[rd_ptr];

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_W'(DEPTH)); // R3
   AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) (full && push) |-> pop); // R4
   AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop); // R5
   AST_POP_ONLY_DEC: assert property (@(posedge clk) disable iff (!rst_n) (pop && !push) |=> count == $past(count) - CNT_W'(1)); // R2

endmodule

// File: rtl/ir_rxbuf_flags.sv
module ir_rxbuf_flags
   import ir_rxbuf_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int LVL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf_evt,
   input  logic             pend_evt,
   input  logic             clr_ovf,
   input  logic             clr_pend,
   input  logic [CNT_W-1:0] count,
   input  logic [LVL_W-1:0] level,
   output rxbuf_flags_t     flags
);

   if (LVL_W > CNT_W) begin : g_bad_level
      $error("ir_rxbuf_flags: trigger level wider than count");
   end

   logic ovf_q, pend_q;
   logic [CNT_W-1:0] level_ext;

   assign level_ext = CNT_W'(level);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ovf_q  <= ovf_evt  | (ovf_q  & ~clr_ovf);
         pend_q <= pend_evt | (pend_q & ~clr_pend);
      end
   end

   assign flags.ovf   = ovf_q;
   assign flags.pend  = pend_q;
   assign flags.avail = (count > level_ext);

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flags.ovf && !clr_ovf) |=> flags.ovf); // R4
   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n) pend_evt |=> flags.pend); // R6
   AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (clr_ovf && !ovf_evt) |=> !flags.ovf); // R7
   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (clr_pend && !pend_evt) |=> !flags.pend); // R7

endmodule

// File: rtl/ir_rxbuf_regs.sv
module ir_rxbuf_regs
   import ir_rxbuf_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7,
   parameter int LVL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sel,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [DATA_W-1:0] head,
   input  logic [CNT_W-1:0]  count,
   input  rxbuf_flags_t      flags,
   output logic [REG_W-1:0]  rdata,
   output logic [LVL_W-1:0]  level,
   output logic              clr_ovf,
   output logic              clr_pend,
   output logic              irq
);

   if (FIELD_LSB + CNT_W > REG_W) begin : g_bad_count_field
      $error("ir_rxbuf_regs: count field does not fit the register");
   end
   if (DATA_W > REG_W) begin : g_bad_data_field
      $error("ir_rxbuf_regs: data wider than the register");
   end

   rxbuf_flags_t en_q;
   logic [LVL_W-1:0] level_q;
   logic wr_ien, wr_stat;
   logic unused_wbits;

   assign wr_ien  = wr && (sel == SEL_IEN);
   assign wr_stat = wr && (sel == SEL_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         level_q <= '0;
      end else if (wr_ien) begin
         en_q.ovf   <= wdata[BIT_OVF];
         en_q.pend  <= wdata[BIT_PEND];
         en_q.avail <= wdata[BIT_AVAIL];
         level_q    <= wdata[FIELD_LSB +: LVL_W];
      end
   end

   assign clr_ovf  = wr_stat && wdata[BIT_OVF];
   assign clr_pend = wr_stat && wdata[BIT_PEND];
   assign level    = level_q;
   assign unused_wbits = ^{wdata[REG_W-1:FIELD_LSB+LVL_W], wdata[FIELD_LSB-1:BIT_AVAIL+1],
                           wdata[BIT_AVAIL-1:BIT_PEND+1]};

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DATA: rdata[DATA_W-1:0] = head;
         SEL_IEN: begin
            rdata[BIT_OVF]   = en_q.ovf;
            rdata[BIT_PEND]  = en_q.pend;
            rdata[BIT_AVAIL] = en_q.avail;
            rdata[FIELD_LSB +: LVL_W] = level_q;
         end
         SEL_STAT: begin
            rdata[BIT_OVF]   = flags.ovf;
            rdata[BIT_PEND]  = flags.pend;
            rdata[BIT_AVAIL] = flags.avail;
            rdata[FIELD_LSB +: CNT_W] = count;
         end
         default: rdata = '0;
      endcase
   end

   assign irq = |(flags & en_q);

   AST_IRQ_ON_AVAIL: assert property (@(posedge clk) disable iff (!rst_n) (flags.avail && en_q.avail) |-> irq); // R9
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (flags == '0) |-> !irq); // R9
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_ien |=> $stable(level_q)); // R11

endmodule

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer
   import ir_rxbuf_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        smp_valid,
   input  logic [7:0]  smp_byte,
   input  logic        smp_pkt_end,
   input  logic [1:0]  reg_sel,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);

   localparam int DATA_W = 8;
   localparam int REG_W  = 32;
   localparam int CNT_W  = $clog2(2 * DEPTH);
   localparam int LVL_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("ir_rx_buffer: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] fifo_head;
   logic [CNT_W-1:0]  fifo_count;
   logic              fifo_full, fifo_empty;
   logic              pop_ok, push_ok, ovf_evt;
   logic              clr_ovf, clr_pend;
   logic [LVL_W-1:0]  level;
   rxbuf_flags_t      flags;

   assign pop_ok  = reg_rd && (reg_sel == SEL_DATA) && !fifo_empty;
   assign push_ok = smp_valid && (!fifo_full || pop_ok);
   assign ovf_evt = smp_valid && !push_ok;

   ir_rxbuf_store #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (smp_byte),
      .head  (fifo_head),
      .count (fifo_count),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   ir_rxbuf_flags #(
      .CNT_W (CNT_W),
      .LVL_W (LVL_W)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_evt  (ovf_evt),
      .pend_evt (smp_pkt_end),
      .clr_ovf  (clr_ovf),
      .clr_pend (clr_pend),
      .count    (fifo_count),
      .level    (level),
      .flags    (flags)
   );

   ir_rxbuf_regs #(
      .REG_W  (REG_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .LVL_W  (LVL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (reg_sel),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .head     (fifo_head),
      .count    (fifo_count),
      .flags    (flags),
      .rdata    (reg_rdata),
      .level    (level),
      .clr_ovf  (clr_ovf),
      .clr_pend (clr_pend),
      .irq      (irq)
   );

   AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_sel == SEL_DATA && fifo_empty && !smp_valid) |=> fifo_count == $past(fifo_count)); // R5
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && fifo_full && pop_ok) |=> (fifo_full && flags.ovf == $past(flags.ovf && !clr_ovf))); // R10
   AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && fifo_full && !pop_ok) |=> (flags.ovf && fifo_full)); // R4

endmodule

// File: tb/tb_ir_rx_buffer.sv
`timescale 1ns/1ps
module tb_ir_rx_buffer;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_byte = '0;
   logic        smp_pkt_end = 1'b0;
   logic [1:0]  reg_sel = 2'd2;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ir_rx_buffer #(.DEPTH(DEPTH)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .smp_byte    (smp_byte),
      .smp_pkt_end (smp_pkt_end),
      .reg_sel     (reg_sel),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq)
   );

   // Behavioural reference model
   logic [7:0] q[$];
   bit m_ovf, m_pend, m_en_ovf, m_en_pend, m_en_avail;
   int m_level;
   bit m_pop, m_push;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_ovf = 0; m_pend = 0;
         m_en_ovf = 0; m_en_pend = 0; m_en_avail = 0;
         m_level = 0;
      end else begin
         m_pop  = reg_rd && reg_sel == 2'd0 && q.size() > 0;
         m_push = smp_valid && (q.size() < DEPTH || m_pop);
         m_ovf  = (smp_valid && !m_push) || (m_ovf && !(reg_wr && reg_sel == 2'd2 && reg_wdata[0]));
         m_pend = smp_pkt_end || (m_pend && !(reg_wr && reg_sel == 2'd2 && reg_wdata[1]));
         if (m_pop) void'(q.pop_front());
         if (m_push) q.push_back(smp_byte);
         if (reg_wr && reg_sel == 2'd1) begin
            m_en_ovf   = reg_wdata[0];
            m_en_pend  = reg_wdata[1];
            m_en_avail = reg_wdata[4];
            m_level    = int'(reg_wdata[13:8]);
         end
      end
   end

   function automatic bit m_avail();
      return q.size() > m_level;
   endfunction

   function automatic logic [31:0] m_rdata();
      logic [31:0] v = '0;
      case (reg_sel)
         2'd0: v[7:0] = (q.size() > 0) ? q[0] : 8'h00;
         2'd1: begin
            v[0] = m_en_ovf; v[1] = m_en_pend; v[4] = m_en_avail;
            v[13:8] = m_level[5:0];
         end
         2'd2: begin
            v[0] = m_ovf; v[1] = m_pend; v[4] = m_avail();
            v[14:8] = 7'(q.size());
         end
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         check(reg_sel == 2'd0 ? "R2 data" : (reg_sel == 2'd1 ? "R11 enables" : "R3 status"),
               reg_rdata, m_rdata());
         check("R9 irq", {31'd0, irq},
               {31'd0, (m_ovf && m_en_ovf) || (m_pend && m_en_pend) || (m_avail() && m_en_avail)});
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] b);
      smp_valid = 1'b1; smp_byte = b;
      cyc();
      smp_valid = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      cyc();
      reg_wr = 1'b0; reg_sel = 2'd2;
   endtask

   task automatic read_byte(output logic [7:0] b);
      reg_sel = 2'd0; reg_rd = 1'b1;
      #1;
      b = reg_rdata[7:0];
      cyc();
      reg_rd = 1'b0; reg_sel = 2'd2;
   endtask

   task automatic peek(input logic [1:0] s, output logic [31:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
      reg_sel = 2'd2;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  b;
      logic [7:0]  exp_seq[$];

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      peek(2'd2, v); check("R1 status", v, 32'h0);
      peek(2'd1, v); check("R1 enables", v, 32'h0);
      peek(2'd0, v); check("R1 data", v, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);

      // R11 enable register fields
      reg_write(2'd1, 32'hFFFF_FFFF);
      peek(2'd1, v); check("R11 masked readback", v, 32'h0000_3F13);
      reg_write(2'd1, 32'h0000_1F13);
      peek(2'd1, v); check("R11 readback", v, 32'h0000_1F13);
      peek(2'd3, v); check("R11 select 3", v, 32'h0);

      // R3 count and R2 order
      for (int i = 0; i < 5; i++) push(8'h11 + 8'(i));
      peek(2'd2, v); check("R3 count 5", v, 32'h0000_0500);
      for (int i = 0; i < 5; i++) begin
         read_byte(b); check("R2 order", {24'd0, b}, {24'd0, 8'h11 + 8'(i)});
      end
      peek(2'd2, v); check("R3 count 0", v, 32'h0);

      // R5 empty read
      read_byte(b); check("R5 empty data", {24'd0, b}, 32'h0);
      peek(2'd2, v); check("R5 empty status", v, 32'h0);

      // R8 trigger level boundary (level 31)
      for (int i = 0; i < 31; i++) push(8'h40 + 8'(i));
      peek(2'd2, v); check("R8 count equals level", v, 32'h0000_1F00);
      check("R9 irq low at level", {31'd0, irq}, 32'h0);
      push(8'h5F);
      peek(2'd2, v); check("R8 count above level", v, 32'h0000_2010);
      check("R9 irq on avail", {31'd0, irq}, 32'h1);

      // R4 overflow drops the byte
      for (int i = 0; i < 32; i++) push(8'h80 + 8'(i));
      peek(2'd2, v); check("R3 full count", v, 32'h0000_4010);
      push(8'hEE);
      peek(2'd2, v); check("R4 overflow flag", v, 32'h0000_4011);

      // R8 status write leaves bit 4; R7 clear overflow
      reg_write(2'd2, 32'h0000_0010);
      peek(2'd2, v); check("R8 avail not cleared", v, 32'h0000_4011);
      reg_write(2'd2, 32'h0000_0001);
      peek(2'd2, v); check("R7 overflow cleared", v, 32'h0000_4010);

      // R10 push and pop together while full
      smp_valid = 1'b1; smp_byte = 8'h77; reg_sel = 2'd0; reg_rd = 1'b1;
      #1 b = reg_rdata[7:0];
      cyc();
      smp_valid = 1'b0; reg_rd = 1'b0; reg_sel = 2'd2;
      check("R10 popped head", {24'd0, b}, 32'h40);
      peek(2'd2, v); check("R10 full no overflow", v, 32'h0000_4010);

      // R2/R4 drain: the dropped byte never appears
      for (int i = 1; i < 32; i++) exp_seq.push_back(8'h40 + 8'(i));
      for (int i = 0; i < 32; i++) exp_seq.push_back(8'h80 + 8'(i));
      exp_seq.push_back(8'h77);
      foreach (exp_seq[k]) begin
         read_byte(b); check("R4 drained sequence", {24'd0, b}, {24'd0, exp_seq[k]});
      end
      peek(2'd2, v); check("R3 drained", v, 32'h0);

      // R6 packet end, R7 same-cycle set wins, R7 clear all
      smp_pkt_end = 1'b1; cyc(); smp_pkt_end = 1'b0;
      peek(2'd2, v); check("R6 packet end set", v, 32'h0000_0002);
      check("R9 irq on packet end", {31'd0, irq}, 32'h1);
      smp_pkt_end = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h2; reg_wr = 1'b1;
      cyc();
      smp_pkt_end = 1'b0; reg_wr = 1'b0;
      peek(2'd2, v); check("R7 set beats clear", v, 32'h0000_0002);
      reg_write(2'd2, 32'h0000_00FF);
      peek(2'd2, v); check("R7 clear all", v, 32'h0);

      // R9 masked packet end, R8 level 0
      reg_write(2'd1, 32'h0000_0011);
      smp_pkt_end = 1'b1; cyc(); smp_pkt_end = 1'b0;
      peek(2'd2, v); check("R6 flag while masked", v, 32'h0000_0002);
      check("R9 masked irq", {31'd0, irq}, 32'h0);
      reg_write(2'd2, 32'h0000_0002);
      push(8'h3C);
      peek(2'd2, v); check("R8 level zero", v, 32'h0000_0110);
      check("R9 irq level zero", {31'd0, irq}, 32'h1);
      read_byte(b); check("R2 single byte", {24'd0, b}, 32'h3C);
      cyc();

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule